// File: doc/BRIEF.md
# Bus Remote Wake-Up Pattern Detector

This block runs while a bus interface sits in one of its low-power modes. Its bus input is the already digitised line state, where 1 means dominant. The block looks for a filtered wake pattern made of three phases: a dominant phase of minimum length, then a recessive phase of minimum length, then a second dominant phase of the same minimum length. The whole pattern must finish inside one timeout window. Short glitches and slow or broken patterns therefore never wake the node.

A second path watches a local wake pin. It accepts an edge of either polarity once the new level has held steady for a filter time. Either source sets a sticky flag bit of its own and drives a low notification pulse of fixed length on an active-low receive-side output. The host clears the flags with a clear strobe, or by taking the interface out of low power.

All durations are parameter counts of clock cycles. Both asynchronous inputs pass through synchronisers before use. A sample below means one synchroniser output value per clock.

Top module: `wake_pattern_det`

## Requirements
- R1: After reset, `src_remote` and `src_local` are 0, `wake_flag` is 0 and `rxd_n` is 1.
- R2: With `lowpwr_en` = 1, a bus sequence of at least DOM_MIN dominant samples, then at least REC_MIN recessive samples, then DOM_MIN dominant samples sets `src_remote` and `wake_flag`.
- R3: A first dominant phase shorter than DOM_MIN samples is discarded, and the detector waits for a fresh dominant phase.
- R4: A recessive phase shorter than REC_MIN samples ends the attempt. The dominant phase that follows counts as a new first phase, with the window restarted at that phase.
- R5: The pattern is recognised only if its final required dominant sample falls within WINDOW samples of the first dominant sample of the attempt. Otherwise the attempt is dropped and the search starts again.
- R6: With `lowpwr_en` = 1, a change of `wake_pin` in either direction sets `src_local` once the new level has held for LOCAL_FILT samples. A shorter excursion has no effect.
- R7: Each recognition (remote or local) drives `rxd_n` low for exactly RXD_LEN cycles. `rxd_n` is high at all other times.
- R8: `src_remote` and `src_local` stay set until `flag_clr` is pulsed high or `lowpwr_en` goes low. Either one clears both bits.
- R9: While `lowpwr_en` is 0, no bus pattern or pin edge sets a flag or lowers `rxd_n`. A pin level that is already held when low power is entered is not taken as an edge.
- R10: A third-phase dominant run shorter than DOM_MIN samples does not cause recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_dominant | input | 1 | Digitised bus state, 1 = dominant (asynchronous) |
| wake_pin | input | 1 | Local wake input (asynchronous) |
| lowpwr_en | input | 1 | 1 while the interface is in standby or sleep |
| flag_clr | input | 1 | Host strobe that clears both source flags |
| wake_flag | output | 1 | OR of the two source flags |
| src_remote | output | 1 | Sticky flag: bus pattern recognised |
| src_local | output | 1 | Sticky flag: filtered local pin edge seen |
| rxd_n | output | 1 | Active-low notification pulse |

## Verification
The bus path is driven with a table of phase lengths:
- comfortable patterns and the exact minimum-length pattern, which separate acceptance from rejection at the DOM_MIN and REC_MIN limits;
- a first dominant phase one sample short and a third dominant phase one sample short;
- a pattern that lands on the last sample of the window and one that misses it by one sample, which fix the timeout edge;
- a too-short recessive phase followed by a minimum-length pattern, which passes only if the early re-dominant edge is itself taken as a new first phase.

The pin path is driven with:
- a glitch one sample under the filter time;
- a held rising edge and a held falling edge;
- a level already held when low power is entered.

Together these separate polarity handling from stale-level capture.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DOM1 = 2'd1,
        PH_REC  = 2'd2,
        PH_DOM2 = 2'd3
    } wk_phase_e;

    typedef struct packed {
        logic rem;
        logic loc;
    } wk_src_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wkp_remote_fsm.sv
module wkp_remote_fsm
    import wkp_pkg::*;
#(
    parameter int DOM_MIN = 8,
    parameter int REC_MIN = 8,
    parameter int WINDOW  = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic b_dom,
    output logic hit
);
    localparam int PH_MAX = max2(DOM_MIN, REC_MIN);
    localparam int PW     = cnt_w(PH_MAX);
    localparam int WW     = cnt_w(WINDOW);
    localparam logic [PW-1:0] DOM_T  = PW'(DOM_MIN);
    localparam logic [PW-1:0] DOM_T1 = PW'(DOM_MIN - 1);
    localparam logic [PW-1:0] REC_T  = PW'(REC_MIN);
    localparam logic [PW-1:0] PH_TOP = PW'(PH_MAX);
    localparam logic [WW-1:0] WIN_T  = WW'(WINDOW);

    wk_phase_e       st, st_n;
    logic [PW-1:0]   ph, ph_n;
    logic [WW-1:0]   win, win_n;
    logic [PW-1:0]   ph_inc;

    assign ph_inc = (ph == PH_TOP) ? ph : ph + 1'b1;

    always_comb begin
        st_n  = st;
        ph_n  = ph;
        win_n = win;
        hit   = 1'b0;
        if (st != PH_IDLE && win >= WIN_T) begin
            // window exhausted: drop the attempt, timeout beats completion
            st_n  = PH_IDLE;
            ph_n  = '0;
            win_n = '0;
        end else begin
            case (st)
                PH_IDLE: begin
                    if (b_dom) begin
                        st_n  = PH_DOM1;
                        ph_n  = PW'(1);
                        win_n = WW'(1);
                    end
                end
                PH_DOM1: begin
                    win_n = win + 1'b1;
                    if (b_dom) begin
                        ph_n = ph_inc;
                    end else if (ph >= DOM_T) begin
                        st_n = PH_REC;
                        ph_n = PW'(1);
                    end else begin
                        st_n  = PH_IDLE;
                        ph_n  = '0;
                        win_n = '0;
                    end
                end
                PH_REC: begin
                    win_n = win + 1'b1;
                    if (!b_dom) begin
                        ph_n = ph_inc;
                    end else if (ph >= REC_T) begin
                        st_n = PH_DOM2;
                        ph_n = PW'(1);
                    end else begin
                        // early dominant edge opens a fresh first phase
                        st_n  = PH_DOM1;
                        ph_n  = PW'(1);
                        win_n = WW'(1);
                    end
                end
                default: begin
                    win_n = win + 1'b1;
                    if (!b_dom) begin
                        st_n  = PH_IDLE;
                        ph_n  = '0;
                        win_n = '0;
                    end else if (ph >= DOM_T1) begin
                        hit   = 1'b1;
                        st_n  = PH_IDLE;
                        ph_n  = '0;
                        win_n = '0;
                    end else begin
                        ph_n = ph_inc;
                    end
                end
            endcase
        end
        if (!en) begin
            st_n  = PH_IDLE;
            ph_n  = '0;
            win_n = '0;
            hit   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_IDLE;
            ph  <= '0;
            win <= '0;
        end else begin
            st  <= st_n;
            ph  <= ph_n;
            win <= win_n;
        end
    end
endmodule

// File: rtl/wkp_local_filt.sv
module wkp_local_filt
    import wkp_pkg::*;
#(
    parameter int LOCAL_FILT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pin,
    output logic hit
);
    localparam int FW = cnt_w(LOCAL_FILT);
    localparam logic [FW-1:0] LAST = FW'(LOCAL_FILT - 1);

    logic          level;
    logic [FW-1:0] cnt;
    logic          differs;

    assign differs = (pin != level);
    assign hit     = en && differs && (cnt >= LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
        end else if (!en) begin
            // track the pin so entry into low power sees no stale edge
            level <= pin;
            cnt   <= '0;
        end else if (!differs) begin
            cnt <= '0;
        end else if (hit) begin
            level <= pin;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wake_pattern_det.sv
module wake_pattern_det
    import wkp_pkg::*;
#(
    parameter int DOM_MIN     = 8,
    parameter int REC_MIN     = 8,
    parameter int WINDOW      = 40,
    parameter int LOCAL_FILT  = 6,
    parameter int RXD_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_dominant,
    input  logic wake_pin,
    input  logic lowpwr_en,
    input  logic flag_clr,
    output logic wake_flag,
    output logic src_remote,
    output logic src_local,
    output logic rxd_n
);
    localparam int RW = cnt_w(RXD_LEN);
    localparam logic [RW-1:0] RXD_LOAD = RW'(RXD_LEN);

    logic [1:0] raw_in, syn_in;
    logic       rem_hit, loc_hit;
    wk_src_t    flags;
    logic [RW-1:0] pcnt;

    assign raw_in = {bus_dominant, wake_pin};

    wkp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    wkp_remote_fsm #(.DOM_MIN(DOM_MIN), .REC_MIN(REC_MIN), .WINDOW(WINDOW)) u_remote (
        .clk   (clk),
        .rst   (rst),
        .en    (lowpwr_en),
        .b_dom (syn_in[1]),
        .hit   (rem_hit)
    );

    wkp_local_filt #(.LOCAL_FILT(LOCAL_FILT)) u_local (
        .clk (clk),
        .rst (rst),
        .en  (lowpwr_en),
        .pin (syn_in[0]),
        .hit (loc_hit)
    );

    always_ff @(posedge clk) begin
        if (rst || !lowpwr_en) begin
            flags <= '0;
        end else begin
            // a new event wins over a simultaneous clear
            flags.rem <= rem_hit | (flags.rem & ~flag_clr);
            flags.loc <= loc_hit | (flags.loc & ~flag_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !lowpwr_en)     pcnt <= '0;
        else if (rem_hit || loc_hit) pcnt <= RXD_LOAD;
        else if (pcnt != '0)       pcnt <= pcnt - 1'b1;
    end

    assign src_remote = flags.rem;
    assign src_local  = flags.loc;
    assign wake_flag  = flags.rem | flags.loc;
    assign rxd_n      = (pcnt == '0);
endmodule

// File: rtl/wake_pattern_det_chk.sv
module wake_pattern_det_chk #(
    parameter int RXD_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic lowpwr_en,
    input logic flag_clr,
    input logic wake_flag,
    input logic src_remote,
    input logic src_local,
    input logic rxd_n
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || rxd_n) low_run <= '0;
        else              low_run <= low_run + 1'b1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!src_remote && !src_local && rxd_n));

    // R9
    a_r9_no_wake_awake: assert property (@(posedge clk) disable iff (rst)
        !lowpwr_en |=> (!src_remote && !src_local && rxd_n));

    // R8
    a_r8_remote_sticky: assert property (@(posedge clk) disable iff (rst)
        (lowpwr_en && !flag_clr && src_remote) |=> src_remote);

    // R8
    a_r8_local_sticky: assert property (@(posedge clk) disable iff (rst)
        (lowpwr_en && !flag_clr && src_local) |=> src_local);

    // R7
    a_r7_pulse_has_source: assert property (@(posedge clk) disable iff (rst)
        $fell(rxd_n) |-> (src_remote || src_local));

    // R7
    a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
        low_run <= 16'(RXD_LEN));

    // R2
    a_r2_flag_or: assert property (@(posedge clk) disable iff (rst)
        wake_flag == (src_remote || src_local));
endmodule

bind wake_pattern_det wake_pattern_det_chk #(.RXD_LEN(RXD_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lowpwr_en  (lowpwr_en),
    .flag_clr   (flag_clr),
    .wake_flag  (wake_flag),
    .src_remote (src_remote),
    .src_local  (src_local),
    .rxd_n      (rxd_n)
);

// File: tb/tb_wake_pattern_det.sv
module tb_wake_pattern_det;
    localparam int DOM_MIN    = 8;
    localparam int REC_MIN    = 8;
    localparam int WINDOW     = 40;
    localparam int LOCAL_FILT = 6;
    localparam int RXD_LEN    = 4;
    localparam int NVEC       = 8;

    // phases: dom_a, rec_a, dom_b, rec_b, dom_c, expected remote
    localparam int VEC [NVEC][6] = '{
        '{ 0, 0, 10, 10, 10, 1},   // R2 comfortable
        '{ 0, 0,  8,  8,  8, 1},   // R2 minimum lengths
        '{ 0, 0,  7, 10, 10, 0},   // R3 first dominant short
        '{ 0, 0, 10, 10,  7, 0},   // R10 third dominant short
        '{10, 5,  8,  8,  8, 1},   // R4 early dominant restarts
        '{ 0, 0,  8, 24,  8, 1},   // R5 exactly fills window
        '{ 0, 0,  8, 25,  8, 0},   // R5 one sample over
        '{ 0, 0,  8,  7, 10, 0}    // R4 short recessive
    };

    logic clk = 1'b0;
    logic rst, bus_dominant, wake_pin, lowpwr_en, flag_clr;
    logic wake_flag, src_remote, src_local, rxd_n;
    int   checks = 0;
    int   errors = 0;
    int   low_cnt = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    wake_pattern_det #(
        .DOM_MIN(DOM_MIN), .REC_MIN(REC_MIN), .WINDOW(WINDOW),
        .LOCAL_FILT(LOCAL_FILT), .RXD_LEN(RXD_LEN)
    ) dut (
        .clk(clk), .rst(rst), .bus_dominant(bus_dominant), .wake_pin(wake_pin),
        .lowpwr_en(lowpwr_en), .flag_clr(flag_clr), .wake_flag(wake_flag),
        .src_remote(src_remote), .src_local(src_local), .rxd_n(rxd_n)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rxd_n) low_cnt <= low_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic phase(input logic lvl, input int n);
        if (n > 0) begin
            bus_dominant = lvl;
            wait_cyc(n);
        end
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        wait_cyc(1);
        flag_clr = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        rst = 1'b1; bus_dominant = 1'b0; wake_pin = 1'b0;
        lowpwr_en = 1'b0; flag_clr = 1'b0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 src_remote", src_remote, 0);
        chk("R1 src_local", src_local, 0);
        chk("R1 rxd_n", rxd_n, 1);

        lowpwr_en = 1'b1;
        wait_cyc(5);

        for (int v = 0; v < NVEC; v++) begin
            low_cnt = 0;
            phase(1'b1, VEC[v][0]);
            phase(1'b0, VEC[v][1]);
            phase(1'b1, VEC[v][2]);
            phase(1'b0, VEC[v][3]);
            phase(1'b1, VEC[v][4]);
            bus_dominant = 1'b0;
            wait_cyc(WINDOW + 20);
            $display("vector %0d", v);
            chk("R2/R3/R4/R5/R10 src_remote", src_remote, VEC[v][5]);
            chk("R2 wake_flag", wake_flag, VEC[v][5]);
            chk("R7 rxd_n low cycles", low_cnt, VEC[v][5] * RXD_LEN);
            chk("R6 src_local idle", src_local, 0);
            clear_flags();
            chk("R8 cleared", wake_flag, 0);
        end

        // local pin: glitch one short of filter
        low_cnt = 0;
        wake_pin = 1'b1; wait_cyc(LOCAL_FILT - 1);
        wake_pin = 1'b0; wait_cyc(20);
        chk("R6 glitch ignored", src_local, 0);
        chk("R7 no pulse on glitch", low_cnt, 0);

        // rising edge held
        wake_pin = 1'b1; wait_cyc(20);
        chk("R6 rising accepted", src_local, 1);
        chk("R6 remote untouched", src_remote, 0);
        chk("R7 local pulse length", low_cnt, RXD_LEN);
        wait_cyc(30);
        chk("R8 sticky", src_local, 1);
        clear_flags();
        chk("R8 clear strobe", src_local, 0);

        // falling edge held
        low_cnt = 0;
        wake_pin = 1'b0; wait_cyc(20);
        chk("R6 falling accepted", src_local, 1);
        chk("R7 falling pulse length", low_cnt, RXD_LEN);

        // leaving low power clears
        lowpwr_en = 1'b0; wait_cyc(3);
        chk("R8 exit clears", src_local, 0);

        // no detection while awake
        low_cnt = 0;
        phase(1'b1, 10); phase(1'b0, 10); phase(1'b1, 10);
        bus_dominant = 1'b0;
        wake_pin = 1'b1;
        wait_cyc(WINDOW + 20);
        chk("R9 remote blocked", src_remote, 0);
        chk("R9 local blocked", src_local, 0);
        chk("R9 rxd_n quiet", low_cnt, 0);

        // re-enter with pin already high: no stale edge
        lowpwr_en = 1'b1; wait_cyc(20);
        chk("R9 held level not an edge", src_local, 0);
        chk("R9 rxd_n quiet on entry", low_cnt, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait (cyc > 50000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule